// File: doc/BRIEF.md
# Multi-Channel Match PWM Timer

This block is a prescaled timer/counter with seven match comparators that can also drive up to six pulse-width outputs. A prescaler divides either the clock or the rising edges of an external input. Each divided event advances a 32-bit count. Every match comparator can flag an interrupt, restart the count or freeze it. In PWM mode, match 0 fixes the period for all outputs. Each output is then either single-edge, with its own comparator giving the falling point, or double-edge, with the comparator pair (n-1, n) giving the rising and falling points.

Software configures the block through a plain write port. In PWM mode new comparator values wait in shadow registers. They move to the active set only after software has set the matching release bit, and only at the moment the count restarts from match 0. A duty or period change therefore never produces a partial pulse. The register port is control, not a data stream, so it has no handshake: a write is taken on every clock edge where `wr_en` is high.

Top module: `pwm_timer`

## Requirements
- R1: After reset, `count`, `pwm_out`, `irq_flags` and `irq` are all zero and the timer is stopped.
- R2: Register writes are decoded by `wr_addr`: 0 control (bit0 run, bit1 hold the count and prescaler at zero, bit2 PWM mode, bit3 external count mode); 1 prescale limit; 2 match actions (bits 3i, 3i+1, 3i+2 = interrupt, restart, freeze for comparator i); 3 edge select (bit n-1 set makes output n double-edge); 4 release (writing 1 to bit i arms comparator i); 5 interrupt clear (writing 1 to bit i clears flag i); 8+i shadow value of comparator i.
- R3: With prescale limit P, the count advances once every P+1 source events, and the first advance follows the (P+1)-th event after the run bit is set.
- R4: In external count mode the source events are the rising edges of `ext_in`. The count does not move while `ext_in` is static.
- R5: Outside PWM mode, a comparator with its restart action returns the count to 0 on the advance taken while the count equals its value. A shadow value written outside PWM mode becomes active one cycle later.
- R6: A comparator with its freeze action holds the count at its value and clears the run bit, so the count stays fixed from then on.
- R7: A match on a comparator whose interrupt action is set raises its flag in `irq_flags`. The flag stays set until it is cleared through register 5. `irq` is the OR of all flags.
- R8: In PWM mode the count runs 0, 1, …, M0 and then restarts, so the period is M0+1 counts.
- R9: A single-edge output n is high during counts c < Mn of a period. Mn = 0 keeps it constantly low, and Mn > M0 keeps it constantly high.
- R10: A double-edge output n rises at count A = M(n-1) and falls at count B = Mn. It is high for A ≤ c < B when A < B, for c ≥ A or c < B when A > B, and never when A = B (the clear wins).
- R11: In PWM mode a shadow value is not used until its release bit is set. It then becomes active at the next restart from match 0, and the release bit clears itself at that moment.
- R12: With PWM mode off, every `pwm_out` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| ext_in | input | 1 | External count input (asynchronous) |
| count | output | 32 | Current timer/counter value |
| pwm_out | output | 6 | PWM outputs; bit n-1 is output n |
| irq_flags | output | 7 | Sticky per-comparator interrupt flags |
| irq | output | 1 | OR of all interrupt flags |

## Verification
A corrupt active comparator value or a stuck release bit shows up on `pwm_out` within two periods. The bench sweeps every match position from 0 to beyond the period, for all six outputs and for both edge modes, so a wrong edge or a missed transfer is seen on the first period after the change. Counter faults (a wrong restart, freeze or prescale step) change `count` on the very next advance. The bench compares `count` cycle by cycle against modular arithmetic. A release bit that transfers early is caught inside the same period, because the bench checks the old duty on the counts that follow the release write.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int ADDR_W       = 4;
  localparam int DATA_W       = 32;
  localparam int A_CTRL       = 0;
  localparam int A_PRESCALE   = 1;
  localparam int A_ACTION     = 2;
  localparam int A_EDGE       = 3;
  localparam int A_RELEASE    = 4;
  localparam int A_IRQCLR     = 5;
  localparam int A_MATCH_BASE = 8;
  localparam int ACT_BITS     = 3;
  localparam int ACT_IRQ      = 0;
  localparam int ACT_RESTART  = 1;
  localparam int ACT_FREEZE   = 2;

  // run is the least significant bit of the control word
  typedef struct packed {
    logic ext;
    logic pwm;
    logic hold;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PRE_W     = 32,
  parameter int NUM_MATCH = 7,
  parameter int NUM_OUT   = 6
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [DATA_W-1:0]                   wr_data,
  input  logic                                wrap_i,
  input  logic                                freeze_i,
  input  logic [NUM_MATCH-1:0]                evt_i,
  output ctrl_t                               ctrl_o,
  output logic [PRE_W-1:0]                    pre_limit_o,
  output logic [NUM_MATCH-1:0]                restart_en_o,
  output logic [NUM_MATCH-1:0]                freeze_en_o,
  output logic [NUM_OUT-1:0]                  edge_sel_o,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]     act_o,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]     act_nxt_o,
  output logic [NUM_MATCH-1:0]                irq_flags_o
);
  localparam int ACT_W = ACT_BITS * NUM_MATCH;

  ctrl_t                           ctrl_q;
  logic [PRE_W-1:0]                pre_q;
  logic [ACT_W-1:0]                action_q;
  logic [NUM_OUT-1:0]              edge_q;
  logic [NUM_MATCH-1:0]            rel_q;
  logic [NUM_MATCH-1:0]            flag_q;
  logic [NUM_MATCH-1:0][CNT_W-1:0] shadow_q;
  logic [NUM_MATCH-1:0][CNT_W-1:0] act_q;
  logic [NUM_MATCH-1:0][CNT_W-1:0] act_nxt;
  logic [NUM_MATCH-1:0]            irq_en;

  logic hit_ctrl, hit_pre, hit_action, hit_edge, hit_rel, hit_clr;
  assign hit_ctrl   = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign hit_pre    = wr_en && (wr_addr == ADDR_W'(A_PRESCALE));
  assign hit_action = wr_en && (wr_addr == ADDR_W'(A_ACTION));
  assign hit_edge   = wr_en && (wr_addr == ADDR_W'(A_EDGE));
  assign hit_rel    = wr_en && (wr_addr == ADDR_W'(A_RELEASE));
  assign hit_clr    = wr_en && (wr_addr == ADDR_W'(A_IRQCLR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      pre_q    <= '0;
      action_q <= '0;
      edge_q   <= '0;
    end else begin
      if (hit_ctrl)   ctrl_q   <= ctrl_t'(wr_data[3:0]);
      if (freeze_i)   ctrl_q.run <= 1'b0;  // a freeze beats a simultaneous write
      if (hit_pre)    pre_q    <= wr_data[PRE_W-1:0];
      if (hit_action) action_q <= wr_data[ACT_W-1:0];
      if (hit_edge)   edge_q   <= wr_data[NUM_OUT-1:0];
    end
  end

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
    logic hit_shadow;
    assign hit_shadow      = wr_en && (wr_addr == ADDR_W'(A_MATCH_BASE + i));
    assign irq_en[i]       = action_q[ACT_BITS*i + ACT_IRQ];
    assign restart_en_o[i] = action_q[ACT_BITS*i + ACT_RESTART];
    assign freeze_en_o[i]  = action_q[ACT_BITS*i + ACT_FREEZE];
    // outside PWM mode the active set simply trails the shadow set
    assign act_nxt[i] = (!ctrl_q.pwm || (wrap_i && rel_q[i])) ? shadow_q[i] : act_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q[i] <= '0;
        act_q[i]    <= '0;
      end else begin
        if (hit_shadow) shadow_q[i] <= wr_data[CNT_W-1:0];
        act_q[i] <= act_nxt[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_q  <= '0;
      flag_q <= '0;
    end else begin
      rel_q  <= (wrap_i ? '0 : rel_q) | (hit_rel ? wr_data[NUM_MATCH-1:0] : '0);
      flag_q <= (flag_q & ~(hit_clr ? wr_data[NUM_MATCH-1:0] : '0)) | (evt_i & irq_en);
    end
  end

  assign ctrl_o      = ctrl_q;
  assign pre_limit_o = pre_q;
  assign edge_sel_o  = edge_q;
  assign act_o       = act_q;
  assign act_nxt_o   = act_nxt;
  assign irq_flags_o = flag_q;

  AST_ACTIVE_HELD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.pwm && !wrap_i) |=> $stable(act_q)) else $error("active set changed mid-period"); // R11
  AST_RELEASE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && !hit_rel) |=> (rel_q == '0)) else $error("release bits survived transfer"); // R11
  AST_FREEZE_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |=> !ctrl_q.run) else $error("run bit not cleared by freeze"); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flag_q) && !hit_clr) |=> ((flag_q & $past(flag_q)) == $past(flag_q))) else $error("flag lost"); // R7
endmodule

// File: rtl/pwm_timer_tick.sv
module pwm_timer_tick #(
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic             ext_mode_i,
  input  logic             ext_in,
  input  logic [PRE_W-1:0] pre_limit_i,
  output logic             tick_o
);
  logic [2:0]       sync_q;
  logic [PRE_W-1:0] pc_q;
  logic             src, at_limit;

  assign src      = ext_mode_i ? (sync_q[1] & ~sync_q[2]) : 1'b1;
  assign at_limit = (pc_q >= pre_limit_i);
  assign tick_o   = run_i && !hold_i && src && at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      pc_q   <= '0;
    end else begin
      sync_q <= {sync_q[1:0], ext_in};
      if (hold_i)              pc_q <= '0;
      else if (run_i && src)   pc_q <= at_limit ? '0 : pc_q + 1'b1;
    end
  end

  AST_PRESCALE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !hold_i && src && !tick_o) |=> (pc_q == PRE_W'($past(pc_q) + 1'b1)))
    else $error("prescaler skipped"); // R3
endmodule

// File: rtl/pwm_timer_count.sv
module pwm_timer_count #(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tick_i,
  input  logic                            hold_i,
  input  logic                            pwm_mode_i,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0] act_i,
  input  logic [NUM_MATCH-1:0]            restart_en_i,
  input  logic [NUM_MATCH-1:0]            freeze_en_i,
  output logic [CNT_W-1:0]                count_o,
  output logic [CNT_W-1:0]                count_nxt_o,
  output logic [NUM_MATCH-1:0]            evt_o,
  output logic                            restart_o,
  output logic                            wrap_o,
  output logic                            freeze_o
);
  logic [CNT_W-1:0]     count_q, count_nxt;
  logic [NUM_MATCH-1:0] evt;

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
    assign evt[i] = tick_i && (count_q == act_i[i]);
  end

  assign wrap_o    = pwm_mode_i && evt[0];
  assign restart_o = (|(evt & restart_en_i)) || wrap_o;
  assign freeze_o  = |(evt & freeze_en_i);

  always_comb begin
    if (hold_i)          count_nxt = '0;
    else if (!tick_i)    count_nxt = count_q;
    else if (restart_o)  count_nxt = '0;
    else if (freeze_o)   count_nxt = count_q;
    else                 count_nxt = count_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_nxt;
  end

  assign count_o     = count_q;
  assign count_nxt_o = count_nxt;
  assign evt_o       = evt;

  AST_COUNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !hold_i && !restart_o && !freeze_o) |=> (count_q == CNT_W'($past(count_q) + 1'b1)))
    else $error("count did not advance"); // R3
  AST_RESTART_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> (count_q == '0)) else $error("restart missed"); // R5
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_o && !restart_o) |=> $stable(count_q)) else $error("freeze moved count"); // R6
endmodule

// File: rtl/pwm_timer_outs.sv
module pwm_timer_outs #(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 7,
  parameter int NUM_OUT   = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tick_i,
  input  logic                            restart_i,
  input  logic                            pwm_mode_i,
  input  logic [NUM_OUT-1:0]              edge_sel_i,
  input  logic [CNT_W-1:0]                count_nxt_i,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0] act_nxt_i,
  output logic [NUM_OUT-1:0]              pwm_o
);
  logic [NUM_OUT-1:0] out_q;

  for (genvar n = 1; n <= NUM_OUT; n++) begin : g_out
    logic set_hit, clr_hit, out_nxt;
    assign clr_hit = (count_nxt_i == act_nxt_i[n]);
    assign set_hit = edge_sel_i[n-1] ? (count_nxt_i == act_nxt_i[n-1]) : restart_i;

    always_comb begin
      if (!pwm_mode_i)   out_nxt = 1'b0;
      else if (!tick_i)  out_nxt = out_q[n-1];
      else if (clr_hit)  out_nxt = 1'b0;   // clear wins over set
      else if (set_hit)  out_nxt = 1'b1;
      else               out_nxt = out_q[n-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) out_q[n-1] <= 1'b0;
      else        out_q[n-1] <= out_nxt;
    end

    AST_SINGLE_RISE_AT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_mode_i && !edge_sel_i[n-1] && !restart_i) |=> !$rose(out_q[n-1]))
      else $error("single-edge output rose mid-period"); // R9
  end

  assign pwm_o = out_q;

  AST_IDLE_OUTPUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode_i && !tick_i) |=> $stable(out_q)) else $error("output moved without advance"); // R8
  AST_OFF_MEANS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_mode_i && $past(!pwm_mode_i)) |-> (out_q == '0)) else $error("output high outside PWM mode"); // R12
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PRE_W     = 32,
  parameter int NUM_MATCH = 7,
  parameter int NUM_OUT   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 ext_in,
  output logic [CNT_W-1:0]     count,
  output logic [NUM_OUT-1:0]   pwm_out,
  output logic [NUM_MATCH-1:0] irq_flags,
  output logic                 irq
);
  ctrl_t                           ctrl;
  logic [PRE_W-1:0]                pre_limit;
  logic [NUM_MATCH-1:0]            restart_en, freeze_en, evt;
  logic [NUM_OUT-1:0]              edge_sel;
  logic [NUM_MATCH-1:0][CNT_W-1:0] act, act_nxt;
  logic [CNT_W-1:0]                count_nxt;
  logic                            tick, restart, wrap, freeze;

  pwm_timer_regs #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .NUM_MATCH(NUM_MATCH), .NUM_OUT(NUM_OUT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wrap_i(wrap), .freeze_i(freeze), .evt_i(evt),
    .ctrl_o(ctrl), .pre_limit_o(pre_limit), .restart_en_o(restart_en),
    .freeze_en_o(freeze_en), .edge_sel_o(edge_sel), .act_o(act),
    .act_nxt_o(act_nxt), .irq_flags_o(irq_flags)
  );

  pwm_timer_tick #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(ctrl.run), .hold_i(ctrl.hold),
    .ext_mode_i(ctrl.ext), .ext_in(ext_in), .pre_limit_i(pre_limit), .tick_o(tick)
  );

  pwm_timer_count #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .hold_i(ctrl.hold), .pwm_mode_i(ctrl.pwm),
    .act_i(act), .restart_en_i(restart_en), .freeze_en_i(freeze_en),
    .count_o(count), .count_nxt_o(count_nxt), .evt_o(evt),
    .restart_o(restart), .wrap_o(wrap), .freeze_o(freeze)
  );

  pwm_timer_outs #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .NUM_OUT(NUM_OUT)) u_outs (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .restart_i(restart), .pwm_mode_i(ctrl.pwm),
    .edge_sel_i(edge_sel), .count_nxt_i(count_nxt), .act_nxt_i(act_nxt), .pwm_o(pwm_out)
  );

  assign irq = |irq_flags;
endmodule

// File: tb/pwm_timer_test.sv
module pwm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        ext_in = 1'b0;
  logic [31:0] count;
  logic [5:0]  pwm_out;
  logic [6:0]  irq_flags;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int m [0:6];
  logic [5:0] edge_bits = '0;

  pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_in(ext_in), .count(count), .pwm_out(pwm_out), .irq_flags(irq_flags), .irq(irq)
  );

  always #5ns clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input int addr, input int data);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 32'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic bit expect_out(input int n, input int c);
    int a, b;
    if (!edge_bits[n-1]) return (c < m[n]);             // R9
    a = m[n-1]; b = m[n];                               // R10
    if (a == b) return 1'b0;
    if (a < b)  return (c >= a) && (c < b);
    return (c >= a) || (c < b);
  endfunction

  task automatic check_period(input int samples, input string req);
    int c0;
    c0 = -1;
    for (int j = 0; j < samples; j++) begin
      @(negedge clk);
      if (c0 < 0) c0 = int'(count);
      check(count == 32'((c0 + j) % (m[0] + 1)), "R8 period", count, (c0 + j) % (m[0] + 1));
      for (int n = 1; n <= 6; n++)
        check(pwm_out[n-1] == expect_out(n, int'(count)), req, pwm_out[n-1], expect_out(n, int'(count)));
    end
  endtask

  task automatic load_matches(input int rel);
    for (int i = 1; i <= 6; i++) wr(8 + i, m[i]);
    if (rel != 0) wr(4, rel);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(count == 0, "R1 count", count, 0);
    check(pwm_out == 0, "R1 pwm_out", pwm_out, 0);
    check(irq_flags == 0 && irq == 0, "R1 irq", irq_flags, 0);
    repeat (5) @(negedge clk);
    check(count == 0, "R1 stopped", count, 0);

    // R3 prescaler divide by 3
    wr(0, 2); wr(1, 2); wr(0, 1);
    repeat (30) @(negedge clk);
    check(count == 10, "R3 prescale", count, 10);
    repeat (3) @(negedge clk);
    check(count == 11, "R3 prescale next", count, 11);

    // R4 external edges
    wr(0, 2); wr(1, 0); wr(0, 9);
    repeat (10) @(negedge clk);
    check(count == 0, "R4 static input", count, 0);
    for (int p = 0; p < 5; p++) begin
      ext_in = 1'b1; repeat (3) @(negedge clk);
      ext_in = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check(count == 5, "R4 edge count", count, 5);

    // R5 restart action, R7 interrupt, R12 outputs low, R2 register decode
    wr(0, 2); wr(10, 3); wr(2, 32'hC0); wr(0, 1);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      check(count == 32'(k % 4), "R5 R2 restart sequence", count, k % 4);
      check(pwm_out == 0, "R12 pwm off", pwm_out, 0);
    end
    check(irq_flags == 7'b0000100 && irq, "R7 flag set", irq_flags, 4);
    wr(0, 2);
    repeat (3) @(negedge clk);
    check(irq_flags == 7'b0000100, "R7 flag sticky", irq_flags, 4);
    wr(5, 4);
    check(irq_flags == 0 && !irq, "R7 flag clear", irq_flags, 0);

    // R6 freeze on comparator 1 at 5
    wr(2, 32'h20); wr(9, 5); wr(0, 1);
    repeat (20) @(negedge clk);
    check(count == 5, "R6 freeze", count, 5);
    check(irq == 0, "R7 no irq without action", irq, 0);

    // R9 single-edge sweep, period 5
    wr(0, 2); wr(2, 0); wr(3, 0); edge_bits = '0;
    m[0] = 4; wr(8, 4);
    for (int i = 1; i <= 6; i++) m[i] = i % 7;
    load_matches(0);
    wr(0, 5);
    repeat (12) @(negedge clk);
    check_period(10, "R9 single");
    for (int base = 1; base <= 6; base++) begin
      for (int i = 1; i <= 6; i++) m[i] = (base + i) % 7;
      load_matches(32'h7E);
      repeat (12) @(negedge clk);
      check_period(10, "R9 single sweep");
    end

    // R10 double-edge sweep on outputs 2, 4, 6
    edge_bits = 6'b101010; wr(3, 32'h2A);
    for (int a = 0; a <= 4; a++) begin
      for (int b = 0; b <= 4; b++) begin
        m[1] = a; m[2] = b; m[3] = b; m[4] = a; m[5] = a; m[6] = (a + 2) % 5;
        load_matches(32'h7E);
        repeat (12) @(negedge clk);
        check_period(5, "R10 double");
      end
    end

    // R11 shadow hold, release timing, self-clear
    edge_bits = '0; wr(3, 0);
    m[1] = 2; wr(9, 2); wr(4, 2);
    repeat (12) @(negedge clk);
    check_period(5, "R11 base");
    wr(9, 4);                       // no release: m[1] stays 2
    repeat (12) @(negedge clk);
    check_period(5, "R11 unreleased");
    for (int k = 0; k < 20 && count != 1; k++) @(negedge clk);
    wr(4, 2);                       // released mid-period; count now 2
    check(count == 2, "R11 position", count, 2);
    check(pwm_out[0] == 1'b0, "R11 old value kept", pwm_out[0], 0);
    @(negedge clk);
    check(pwm_out[0] == 1'b0, "R11 old value kept", pwm_out[0], 0);
    @(negedge clk);
    for (int k = 0; k < 20 && count != 3; k++) @(negedge clk);
    check(pwm_out[0] == 1'b1, "R11 new value at restart", pwm_out[0], 1);
    m[1] = 4;
    wr(9, 1);                       // release bit must have cleared
    repeat (12) @(negedge clk);
    check_period(10, "R11 release self-clear");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule